// File: doc/BRIEF.md
# Remote Interrupt Forwarding Controller

This block carries an interrupt raised at the far end of a serial link onto a local active-low interrupt pin. The remote side's interrupt request arrives as an active-low level on the back channel. The block passes that level through a synchronizer and watches it for a falling transition. When a transition arrives while the block is armed, the block latches a sticky pending bit and pulls the local pin low.

A host controller arms forwarding through two bits of one control register. Both a global arm bit and a remote-source enable bit must be set. When the pin goes low, the host reads the interrupt status register to find the source. That read returns the pending bit and clears it, which releases the pin. Clearing either enable bit hides the pending interrupt from the pin but keeps it latched. A remote event that lands in the same cycle as the clearing read is not lost.

The register port is a simple strobe interface. It has an address, a write enable, a read strobe and 8-bit data in each direction. Read data is registered and appears one cycle after the strobe.

Top module: `remote_irq_fwd`

## Requirements
- R1: During and after synchronous reset, `irq_n` is 1, `reg_rdata` is 0, the control register reads 0x00 and no interrupt is pending.
- R2: The control register sits at address 0xC6 and holds only bit 5 (global arm) and bit 0 (remote-source enable). Other written bits read back as 0. Read data shows on `reg_rdata` one cycle after `reg_rd`, and `reg_rdata` is 0 in any cycle that follows no read.
- R3: `remote_irq_n` passes through a two-flop synchronizer. A high-to-low change seen while bits 5 and 0 are both set makes the pending bit 1 at the third clock edge after the change. `irq_n` then goes low at the fourth edge.
- R4: A falling `remote_irq_n` seen while either enable bit is 0 does not set the pending bit. Setting the enables later produces no interrupt. A steady low level produces no further events.
- R5: `irq_n` is registered. It is 0 exactly when, at the previous edge, the pending bit was set and both enable bits were 1. Otherwise it is 1.
- R6: The status register sits at address 0xC7 with the pending flag in bit 0. A read returns the flag and clears it at the same edge, so `irq_n` returns to 1 one edge later.
- R7: If a remote event sets the pending bit in the same cycle as a clearing status read, the pending bit stays set.
- R8: Writing 0 to either enable bit makes `irq_n` 1 at the next edge, and the pending bit is kept. Setting both enable bits again pulls `irq_n` low once more.
- R9: Writes to the status address have no effect. Reads of addresses other than 0xC6 and 0xC7 return 0 and do not clear the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write enable |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid one cycle after `reg_rd` |
| remote_irq_n | input | 1 | Active-low remote interrupt level from the back channel |
| irq_n | output | 1 | Local active-low interrupt pin (high means released) |

## Verification
Directed sequences come first. They separate a fully armed falling edge from edges that arrive with only one enable bit set, and a held low level from a fresh transition. The four-edge pin latency is checked against the three-edge pending latency. A clearing read is timed to coincide with a new event, which shows whether the set takes priority over the clear. Masking and then re-enabling shows whether status is kept while the pin is hidden. Writes to the status address and reads of unmapped addresses probe for side effects. A long stretch of random register traffic and sparse remote toggles then compares the pin and the read data every cycle with a bench model built from the requirements.

// File: rtl/rif_pkg.sv
package rif_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 8;
  localparam logic [REG_AW-1:0] CTRL_ADDR = 8'hC6;
  localparam logic [REG_AW-1:0] STAT_ADDR = 8'hC7;
  localparam int ARM_BIT  = 5;
  localparam int SRC_BIT  = 0;
  localparam int PEND_BIT = 0;
  localparam logic [REG_DW-1:0] CTRL_MASK = REG_DW'((1 << ARM_BIT) | (1 << SRC_BIT));
endpackage

// File: rtl/rif_sync.sv
module rif_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rif_pending.sv
module rif_pending (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pending_o
);
  always_ff @(posedge clk) begin
    if (rst)        pending_o <= 1'b0;
    else if (set_i) pending_o <= 1'b1;
    else if (clr_i) pending_o <= 1'b0;
  end

  // R7: a new event wins over a simultaneous clearing read
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> pending_o);
  // R6: a clearing read with no new event drops the flag
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !pending_o);
  // R8: without set or clear the flag holds, whatever the enables do
  a_r8_pending_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(pending_o));
endmodule

// File: rtl/rif_regs.sv
module rif_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] CTRL_A = 8'hC6,
  parameter logic [AW-1:0] STAT_A = 8'hC7,
  parameter logic [DW-1:0] CMASK  = 8'h21,
  parameter int ARM_B  = 5,
  parameter int SRC_B  = 0,
  parameter int PEND_B = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pending_i,
  output logic [DW-1:0] rdata_o,
  output logic          arm_o,
  output logic          src_en_o,
  output logic          stat_rd_o
);
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] stat_view;
  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst)                          ctrl_q <= '0;
    else if (wr_i && addr_i == CTRL_A) ctrl_q <= wdata_i & CMASK;
  end

  always_comb begin
    stat_view         = '0;
    stat_view[PEND_B] = pending_i;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_i) begin
      if (addr_i == CTRL_A)      rd_mux = ctrl_q;
      else if (addr_i == STAT_A) rd_mux = stat_view;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  assign arm_o     = ctrl_q[ARM_B];
  assign src_en_o  = ctrl_q[SRC_B];
  assign stat_rd_o = rd_i && (addr_i == STAT_A);

  // R2: no strobe, no data on the next cycle
  a_r2_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_o == '0));
  // R9: status address accepts no writes, control only masked bits
  a_r9_ctrl_masked: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q & ~CMASK) == '0));
endmodule

// File: rtl/remote_irq_fwd.sv
module remote_irq_fwd #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [rif_pkg::REG_AW-1:0] reg_addr,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [rif_pkg::REG_DW-1:0] reg_wdata,
  output logic [rif_pkg::REG_DW-1:0] reg_rdata,
  input  logic                      remote_irq_n,
  output logic                      irq_n
);
  import rif_pkg::*;

  logic rem_sync;
  logic rem_prev_q;
  logic arm, src_en, armed;
  logic stat_rd;
  logic pending;
  logic fall_evt;

  rif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (remote_irq_n),
    .q_o (rem_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) rem_prev_q <= 1'b1;
    else     rem_prev_q <= rem_sync;
  end

  assign armed    = arm && src_en;
  assign fall_evt = rem_prev_q && !rem_sync && armed;

  rif_regs #(
    .AW(REG_AW), .DW(REG_DW), .CTRL_A(CTRL_ADDR), .STAT_A(STAT_ADDR),
    .CMASK(CTRL_MASK), .ARM_B(ARM_BIT), .SRC_B(SRC_BIT), .PEND_B(PEND_BIT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (reg_addr),
    .wr_i      (reg_wr),
    .rd_i      (reg_rd),
    .wdata_i   (reg_wdata),
    .pending_i (pending),
    .rdata_o   (reg_rdata),
    .arm_o     (arm),
    .src_en_o  (src_en),
    .stat_rd_o (stat_rd)
  );

  rif_pending u_pend (
    .clk       (clk),
    .rst       (rst),
    .set_i     (fall_evt),
    .clr_i     (stat_rd),
    .pending_o (pending)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !(pending && armed);
  end

  // R5: a disarmed cycle releases the pin on the next edge
  a_r5_mask_release: assert property (@(posedge clk) disable iff (rst)
    !armed |=> irq_n);
  // R5: the pin only falls when a flag was latched
  a_r5_fall_needs_pending: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(pending));
  // R4: the flag only rises while fully armed
  a_r4_set_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(armed));
endmodule

// File: tb/remote_irq_fwd_tb.sv
`timescale 1ns/1ps
module remote_irq_fwd_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       remote_irq_n = 1'b1;
  logic       irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  remote_irq_fwd u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .remote_irq_n(remote_irq_n), .irq_n(irq_n)
  );

  // Requirement-level model, stepped at every rising edge
  logic       m_s1 = 1'b1, m_s2 = 1'b1, m_prev = 1'b1, m_pend = 1'b0, m_irq = 1'b1;
  logic [7:0] m_ctrl = 8'h00, m_rd = 8'h00;

  function automatic logic m_armed(input logic [7:0] c);
    return c[5] && c[0];
  endfunction

  function automatic logic [7:0] m_read(input logic rd, input logic [7:0] a,
                                        input logic [7:0] c, input logic p);
    if (!rd) return 8'h00;
    if (a == 8'hC6) return c;
    if (a == 8'hC7) return {7'b0, p};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    logic set, clr;
    if (rst) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1; m_pend = 1'b0;
      m_irq = 1'b1; m_ctrl = 8'h00; m_rd = 8'h00;
    end else begin
      m_rd   = m_read(reg_rd, reg_addr, m_ctrl, m_pend);
      set    = m_prev && !m_s2 && m_armed(m_ctrl);
      clr    = reg_rd && reg_addr == 8'hC7;
      m_irq  = !(m_pend && m_armed(m_ctrl));
      m_pend = set || (m_pend && !clr);
      if (reg_wr && reg_addr == 8'hC6) m_ctrl = reg_wdata & 8'h21;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = remote_irq_n;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    step();
    reg_rd = 1'b0;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(3);
    chk({7'b0, irq_n}, 8'h01, "R1 irq_n in reset");
    chk(reg_rdata, 8'h00, "R1 rdata in reset");
    rst = 1'b0;
    step();
    chk({7'b0, irq_n}, 8'h01, "R1 irq_n after reset");
    rd(8'hC6, 8'h00, "R1 ctrl reset value");
    rd(8'hC7, 8'h00, "R1 no pending after reset");

    wr(8'hC6, 8'hFF);
    rd(8'hC6, 8'h21, "R2 ctrl keeps only bits 5 and 0");
    step();
    chk(reg_rdata, 8'h00, "R2 rdata zero without read");

    remote_irq_n = 1'b0;
    step(3);
    chk({7'b0, irq_n}, 8'h01, "R3 pin still high at third edge");
    step();
    chk({7'b0, irq_n}, 8'h00, "R3 pin low at fourth edge");
    rd(8'hC7, 8'h01, "R6 status shows pending");
    step();
    chk({7'b0, irq_n}, 8'h01, "R6 pin released after read");
    rd(8'hC7, 8'h00, "R6 status cleared by read");
    step(4);
    chk({7'b0, irq_n}, 8'h01, "R4 held low level is no new event");
    remote_irq_n = 1'b1;
    step(4);

    remote_irq_n = 1'b0;
    step(4);
    chk({7'b0, irq_n}, 8'h00, "R3 second event");
    wr(8'hC6, 8'h01);
    step();
    chk({7'b0, irq_n}, 8'h01, "R8 pin masked by clearing arm");
    wr(8'hC6, 8'h21);
    step();
    chk({7'b0, irq_n}, 8'h00, "R8 pending kept, pin low again");
    rd(8'hC7, 8'h01, "R8 status kept while masked");
    remote_irq_n = 1'b1;
    step(4);

    wr(8'hC6, 8'h20);
    remote_irq_n = 1'b0;
    step(5);
    wr(8'hC6, 8'h21);
    step(2);
    chk({7'b0, irq_n}, 8'h01, "R4 event with source disabled ignored");
    rd(8'hC7, 8'h00, "R4 no pending from unarmed event");
    remote_irq_n = 1'b1;
    step(4);

    remote_irq_n = 1'b0;
    step(4);
    remote_irq_n = 1'b1;
    step(4);
    remote_irq_n = 1'b0;
    step(2);
    reg_addr = 8'hC7; reg_rd = 1'b1;
    step();
    reg_rd = 1'b0;
    chk(reg_rdata, 8'h01, "R7 read during collision");
    step();
    chk({7'b0, irq_n}, 8'h00, "R7 pending survives collision");
    wr(8'hC7, 8'h00);
    rd(8'h10, 8'h00, "R9 unmapped read is zero");
    step();
    chk({7'b0, irq_n}, 8'h00, "R9 status write and other read no effect");
    rd(8'hC7, 8'h01, "R9 pending still set");
    remote_irq_n = 1'b1;
    step(4);

    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if ($urandom_range(0, 15) == 0) remote_irq_n = ~remote_irq_n;
      reg_wr = 1'b0; reg_rd = 1'b0;
      case ($urandom_range(0, 2))
        0: reg_addr = 8'hC6;
        1: reg_addr = 8'hC7;
        default: reg_addr = 8'($urandom);
      endcase
      reg_wdata = 8'($urandom);
      if (sel < 10)      reg_wr = 1'b1;
      else if (sel < 35) reg_rd = 1'b1;
      step();
      chk(reg_rdata, m_rd, "R2 R6 random read data");
      chk({7'b0, irq_n}, {7'b0, m_irq}, "R5 random pin");
    end
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
  end
endmodule